// File: doc/BRIEF.md
# HDLC Receive Header Field Extractor

This block sits behind the bit de-stuffing stage of an HDLC receiver. It takes the received octet stream, one octet per valid cycle, with markers for the first and last octet of each frame. It splits each frame into an address field, a control field, a payload stream and the trailing frame check sequence (FCS). The address and control fields are each one or two octets long. Their length is decided per frame from extension bits in the received octets, and configuration force bits can override that decision. A bypass setting treats the whole frame, header included, as payload. The FCS octets are always kept out of the payload, whether or not the CRC is checked further downstream.

The configuration inputs are sampled on the first octet of a frame and held for the rest of that frame. The trailing FCS is 2 or 4 octets long, and its position is only known when the last octet arrives. For that reason payload octets are held back by the FCS length before they are released. Every output is registered and appears in the cycle after the input octet that caused it. CRC calculation and address-match decisions belong to other blocks.

Top module: `hdlc_addr_ctrl_extract`

## Requirements
- R1: After reset, hdrValid, dataValid, dataLast, fcsValid and shortErr are 0, and addrOut, addrTwo, ctrlOut and ctrlTwo are 0.
- R2: When bypass is 1 at frame start, every octet of the frame except the trailing FCS octets is output on dataOut in arrival order, and hdrValid never pulses for that frame.
- R3: With bypass 0, extended address on and promiscuous 0, the address is two octets when bit 0 of the first address octet is 0, and one octet otherwise. With extended address off it is always one octet. addrOut[7:0] holds the first address octet, addrOut[15:8] holds the second (0 for a one-octet address), and addrTwo gives the length.
- R4: With extended address on, the address-force input makes the address two octets regardless of bit 0. Force without extended address has no effect.
- R5: With extended control on (bypass 0, promiscuous 0), the control field is one octet when bits [1:0] of its first octet are 2'b11 and two octets otherwise. With extended control off it is one octet. ctrlOut and ctrlTwo are laid out like the address outputs.
- R6: With extended control on, the control-force input makes the control field two octets regardless of its low bits. Force without extended control has no effect.
- R7: With promiscuous 1, both fields are one octet whatever the extension, force and data bits are.
- R8: The last 2 octets (fcsLong 0) or 4 octets (fcsLong 0 replaced by 1) of a frame never appear on dataOut. They pulse on fcsOut with fcsValid one cycle after the last octet. The octets are right-aligned, the earliest received octet is the most significant, and the unused upper bits are 0.
- R9: dataLast marks the final payload octet. It is asserted in the same cycle as fcsValid, and hdrValid pulses one cycle after the octet that completes the header.
- R10: A frame whose octet count is below header length plus FCS length pulses shortErr after its last octet. It outputs no payload octet and no fcsValid.
- R11: A start-of-frame octet arriving while a frame is still open discards the open frame's held octets and header progress and starts a new frame.
- R12: Configuration changes made after the start-of-frame octet do not affect the frame in progress.
- R13: Valid octets arriving outside a frame (after its last octet and before the next start marker) produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input octet valid |
| inData | input | 8 | De-stuffed received octet |
| inSof | input | 1 | Octet is the first of a frame |
| inEof | input | 1 | Octet is the last of a frame |
| cfgBypass | input | 1 | Treat header octets as payload |
| cfgPromisc | input | 1 | Disable extended field handling |
| cfgExtAddr | input | 1 | Enable two-octet address detection |
| cfgExtCtrl | input | 1 | Enable two-octet control detection |
| cfgForceAddr | input | 1 | Force two-octet address when extended address is on |
| cfgForceCtrl | input | 1 | Force two-octet control when extended control is on |
| cfgFcsLong | input | 1 | FCS is 4 octets (1) or 2 octets (0) |
| hdrValid | output | 1 | Header fields captured (one-cycle pulse) |
| addrOut | output | 16 | Captured address, first octet in the low byte |
| addrTwo | output | 1 | Address was two octets |
| ctrlOut | output | 16 | Captured control, first octet in the low byte |
| ctrlTwo | output | 1 | Control was two octets |
| dataValid | output | 1 | Payload octet valid |
| dataOut | output | 8 | Payload octet |
| dataLast | output | 1 | Final payload octet of the frame |
| fcsValid | output | 1 | FCS octets valid (one-cycle pulse) |
| fcsOut | output | 32 | Trailing FCS octets, right-aligned |
| shortErr | output | 1 | Frame too short (one-cycle pulse) |

## Verification
The last octet of a frame both releases the final held payload octet and closes the FCS window. dataLast, dataValid and fcsValid must therefore rise together in one cycle, or fcsValid must rise alone when the payload is empty. The bench drives frames of exact boundary lengths (header plus FCS, one octet more, one octet less) in both FCS sizes, with and without idle gaps. A behavioural queue model predicts every output each cycle. The same last octet can also decide between the FCS pulse and the short-frame pulse, so lengths on each side of that boundary are compared cycle by cycle.

// File: rtl/hdlc_acx_pkg.sv
package hdlc_acx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_CTRL_LO,
    ST_CTRL_HI,
    ST_BODY
  } rxPhase_e;

  // per-frame configuration, latched on the start octet
  typedef struct packed {
    logic bypass;
    logic promisc;
    logic extAddr;
    logic extCtrl;
    logic forceAddr;
    logic forceCtrl;
    logic fcsLong;
  } acxCfg_t;

  // strobes from control to datapath, valid for the current input octet
  typedef struct packed {
    logic flush;
    logic capAddrLo;
    logic capAddrHi;
    logic capCtrlLo;
    logic capCtrlHi;
    logic addrTwo;
    logic ctrlTwo;
    logic hdrDone;
    logic push;
    logic last;
    logic fcsLong;
  } acxStrobe_t;

endpackage

// File: rtl/hdlc_acx_ctrl.sv
module hdlc_acx_ctrl
  import hdlc_acx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic [1:0] lowBits,
  input  acxCfg_t    cfgIn,
  output acxStrobe_t strb
);

  rxPhase_e phase, curPhase, nextPhase;
  acxCfg_t  cfgLat, cfgNow;
  logic     sofHit, extAddrOn, extCtrlOn, addrWide, ctrlWide;

  assign sofHit = inValid & inSof;

  always_comb begin
    cfgNow    = sofHit ? cfgIn : cfgLat;
    curPhase  = sofHit ? (cfgIn.bypass ? ST_BODY : ST_ADDR_LO) : phase;
    extAddrOn = cfgNow.extAddr & ~cfgNow.promisc;
    extCtrlOn = cfgNow.extCtrl & ~cfgNow.promisc;
    addrWide  = extAddrOn & (cfgNow.forceAddr | ~lowBits[0]);
    ctrlWide  = extCtrlOn & (cfgNow.forceCtrl | (lowBits != 2'b11));
  end

  always_comb begin
    strb         = '0;
    strb.flush   = sofHit;
    strb.fcsLong = cfgNow.fcsLong;
    strb.addrTwo = addrWide;
    strb.ctrlTwo = ctrlWide;
    nextPhase    = curPhase;
    if (inValid && curPhase != ST_IDLE) begin
      case (curPhase)
        ST_ADDR_LO: begin
          strb.capAddrLo = 1'b1;
          nextPhase      = addrWide ? ST_ADDR_HI : ST_CTRL_LO;
        end
        ST_ADDR_HI: begin
          strb.capAddrHi = 1'b1;
          nextPhase      = ST_CTRL_LO;
        end
        ST_CTRL_LO: begin
          strb.capCtrlLo = 1'b1;
          strb.hdrDone   = ~ctrlWide;
          nextPhase      = ctrlWide ? ST_CTRL_HI : ST_BODY;
        end
        ST_CTRL_HI: begin
          strb.capCtrlHi = 1'b1;
          strb.hdrDone   = 1'b1;
          nextPhase      = ST_BODY;
        end
        default: strb.push = 1'b1;
      endcase
      if (inEof) begin
        strb.last = 1'b1;
        nextPhase = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      cfgLat <= '0;
    end else begin
      phase <= nextPhase;
      if (sofHit) cfgLat <= cfgIn;
    end
  end

endmodule

// File: rtl/hdlc_acx_dpath.sv
module hdlc_acx_dpath
  import hdlc_acx_pkg::*;
#(
  parameter int OCTET_W          = 8,
  parameter int FCS_SHORT_OCTETS = 2,
  parameter int FCS_LONG_OCTETS  = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [OCTET_W-1:0]                 inData,
  input  acxStrobe_t                         strb,
  output logic                               hdrValid,
  output logic [2*OCTET_W-1:0]               addrOut,
  output logic                               addrTwo,
  output logic [2*OCTET_W-1:0]               ctrlOut,
  output logic                               ctrlTwo,
  output logic                               dataValid,
  output logic [OCTET_W-1:0]                 dataOut,
  output logic                               dataLast,
  output logic                               fcsValid,
  output logic [FCS_LONG_OCTETS*OCTET_W-1:0] fcsOut,
  output logic                               shortErr
);

  localparam int CNT_W = $clog2(FCS_LONG_OCTETS + 2);
  localparam int FCS_W = FCS_LONG_OCTETS * OCTET_W;
  localparam logic [CNT_W-1:0] NEED_S = CNT_W'(FCS_SHORT_OCTETS);
  localparam logic [CNT_W-1:0] NEED_L = CNT_W'(FCS_LONG_OCTETS);

  logic [OCTET_W-1:0] hold [FCS_LONG_OCTETS];
  logic [OCTET_W-1:0] win  [FCS_LONG_OCTETS];
  logic [CNT_W-1:0]   cnt, baseCnt, cntInc, need;
  logic [OCTET_W-1:0] emitOct;
  logic [FCS_W-1:0]   fcsNext;
  logic               emit, shortNow;

  always_comb begin
    baseCnt  = strb.flush ? '0 : cnt;
    need     = strb.fcsLong ? NEED_L : NEED_S;
    cntInc   = baseCnt + CNT_W'(1);
    emit     = strb.push && (baseCnt == need);
    shortNow = strb.last && (!strb.push || (cntInc < need));
    emitOct  = '0;
    for (int i = 0; i < FCS_LONG_OCTETS; i++) begin
      if (CNT_W'(i + 1) == need) emitOct = hold[i];
    end
  end

  // window of the newest octets including the current one
  genvar j;
  generate
    for (j = 0; j < FCS_LONG_OCTETS; j++) begin : g_win
      if (j == 0) begin : g_new
        assign win[j] = inData;
      end else begin : g_old
        assign win[j] = hold[j-1];
      end
      if (j < FCS_SHORT_OCTETS) begin : g_always
        assign fcsNext[j*OCTET_W +: OCTET_W] = win[j];
      end else begin : g_longOnly
        assign fcsNext[j*OCTET_W +: OCTET_W] = strb.fcsLong ? win[j] : '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FCS_LONG_OCTETS; i++) hold[i] <= '0;
      cnt       <= '0;
      hdrValid  <= 1'b0;
      addrOut   <= '0;
      addrTwo   <= 1'b0;
      ctrlOut   <= '0;
      ctrlTwo   <= 1'b0;
      dataValid <= 1'b0;
      dataOut   <= '0;
      dataLast  <= 1'b0;
      fcsValid  <= 1'b0;
      fcsOut    <= '0;
      shortErr  <= 1'b0;
    end else begin
      if (strb.capAddrLo) begin
        addrOut <= {{OCTET_W{1'b0}}, inData};
        addrTwo <= strb.addrTwo;
      end
      if (strb.capAddrHi) addrOut[2*OCTET_W-1:OCTET_W] <= inData;
      if (strb.capCtrlLo) begin
        ctrlOut <= {{OCTET_W{1'b0}}, inData};
        ctrlTwo <= strb.ctrlTwo;
      end
      if (strb.capCtrlHi) ctrlOut[2*OCTET_W-1:OCTET_W] <= inData;
      hdrValid <= strb.hdrDone;

      if (strb.push) begin
        for (int i = FCS_LONG_OCTETS - 1; i > 0; i--) hold[i] <= hold[i-1];
        hold[0] <= inData;
      end
      if (strb.last)      cnt <= '0;
      else if (strb.push) cnt <= emit ? need : cntInc;
      else                cnt <= baseCnt;

      dataValid <= emit;
      if (emit) dataOut <= emitOct;
      dataLast <= emit && strb.last;
      fcsValid <= strb.last && !shortNow;
      if (strb.last && !shortNow) fcsOut <= fcsNext;
      shortErr <= shortNow;
    end
  end

endmodule

// File: rtl/hdlc_addr_ctrl_extract.sv
module hdlc_addr_ctrl_extract
  import hdlc_acx_pkg::*;
#(
  parameter int OCTET_W          = 8,
  parameter int FCS_SHORT_OCTETS = 2,
  parameter int FCS_LONG_OCTETS  = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic [OCTET_W-1:0]                 inData,
  input  logic                               inSof,
  input  logic                               inEof,
  input  logic                               cfgBypass,
  input  logic                               cfgPromisc,
  input  logic                               cfgExtAddr,
  input  logic                               cfgExtCtrl,
  input  logic                               cfgForceAddr,
  input  logic                               cfgForceCtrl,
  input  logic                               cfgFcsLong,
  output logic                               hdrValid,
  output logic [2*OCTET_W-1:0]               addrOut,
  output logic                               addrTwo,
  output logic [2*OCTET_W-1:0]               ctrlOut,
  output logic                               ctrlTwo,
  output logic                               dataValid,
  output logic [OCTET_W-1:0]                 dataOut,
  output logic                               dataLast,
  output logic                               fcsValid,
  output logic [FCS_LONG_OCTETS*OCTET_W-1:0] fcsOut,
  output logic                               shortErr
);

  acxCfg_t    cfgIn;
  acxStrobe_t strb;

  always_comb begin
    cfgIn.bypass    = cfgBypass;
    cfgIn.promisc   = cfgPromisc;
    cfgIn.extAddr   = cfgExtAddr;
    cfgIn.extCtrl   = cfgExtCtrl;
    cfgIn.forceAddr = cfgForceAddr;
    cfgIn.forceCtrl = cfgForceCtrl;
    cfgIn.fcsLong   = cfgFcsLong;
  end

  hdlc_acx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .inEof   (inEof),
    .lowBits (inData[1:0]),
    .cfgIn   (cfgIn),
    .strb    (strb)
  );

  hdlc_acx_dpath #(
    .OCTET_W          (OCTET_W),
    .FCS_SHORT_OCTETS (FCS_SHORT_OCTETS),
    .FCS_LONG_OCTETS  (FCS_LONG_OCTETS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .strb      (strb),
    .hdrValid  (hdrValid),
    .addrOut   (addrOut),
    .addrTwo   (addrTwo),
    .ctrlOut   (ctrlOut),
    .ctrlTwo   (ctrlTwo),
    .dataValid (dataValid),
    .dataOut   (dataOut),
    .dataLast  (dataLast),
    .fcsValid  (fcsValid),
    .fcsOut    (fcsOut),
    .shortErr  (shortErr)
  );

endmodule

// File: rtl/hdlc_acx_chk.sv
module hdlc_acx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inSof,
  input logic inEof,
  input logic cfgBypass,
  input logic hdrValid,
  input logic dataValid,
  input logic dataLast,
  input logic fcsValid,
  input logic shortErr
);

  // R10: a frame ends either good or short, never both
  assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(shortErr && fcsValid));

  // R10: the short flag only follows a last octet
  assert_short_after_eof_R10: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |-> $past(inValid && inEof));

  // R8: FCS release only follows a last octet
  assert_fcs_after_eof_R8: assert property (@(posedge clk) disable iff (!rstN)
    fcsValid |-> $past(inValid && inEof));

  // R9: last marker rides on a payload octet, together with the FCS pulse
  assert_last_is_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataLast |-> (dataValid && fcsValid));

  // R2: a bypass frame start never reports a header
  assert_bypass_no_hdr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && cfgBypass) |=> !hdrValid);

  // R13: payload only follows an accepted octet
  assert_data_follows_octet_R13: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(inValid));

endmodule

bind hdlc_addr_ctrl_extract hdlc_acx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inSof     (inSof),
  .inEof     (inEof),
  .cfgBypass (cfgBypass),
  .hdrValid  (hdrValid),
  .dataValid (dataValid),
  .dataLast  (dataLast),
  .fcsValid  (fcsValid),
  .shortErr  (shortErr)
);

// File: tb/hdlc_addr_ctrl_extract_tb.sv
module hdlc_addr_ctrl_extract_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, inValid, inSof, inEof;
  logic [7:0] inData;
  logic cfgBypass, cfgPromisc, cfgExtAddr, cfgExtCtrl, cfgForceAddr, cfgForceCtrl, cfgFcsLong;
  logic hdrValid, addrTwo, ctrlTwo, dataValid, dataLast, fcsValid, shortErr;
  logic [15:0] addrOut, ctrlOut;
  logic [7:0]  dataOut;
  logic [31:0] fcsOut;

  hdlc_addr_ctrl_extract u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof),
    .cfgBypass(cfgBypass), .cfgPromisc(cfgPromisc), .cfgExtAddr(cfgExtAddr),
    .cfgExtCtrl(cfgExtCtrl), .cfgForceAddr(cfgForceAddr), .cfgForceCtrl(cfgForceCtrl),
    .cfgFcsLong(cfgFcsLong), .hdrValid(hdrValid), .addrOut(addrOut), .addrTwo(addrTwo),
    .ctrlOut(ctrlOut), .ctrlTwo(ctrlTwo), .dataValid(dataValid), .dataOut(dataOut),
    .dataLast(dataLast), .fcsValid(fcsValid), .fcsOut(fcsOut), .shortErr(shortErr)
  );

  int    nChecks = 0;
  int    nErrors = 0;
  string curReq  = "R1";

  // reference model state
  bit         mInFrame = 0;
  int         mPhase   = 0;
  bit         mByp, mProm, mEA, mEC, mFA, mFC, mFL;
  logic [7:0] mq[$];
  logic [7:0] frm[$];

  // expected outputs
  bit          eHdr = 0, eA2 = 0, eC2 = 0, eDv = 0, eLast = 0, eFcsV = 0, eShort = 0;
  logic [15:0] eAddr = '0, eCtrl = '0;
  logic [7:0]  eData = '0;
  logic [31:0] eFcs  = '0;

  task automatic setCfg(bit b, bit p, bit ea, bit ec, bit fa, bit fc, bit fl);
    cfgBypass = b; cfgPromisc = p; cfgExtAddr = ea; cfgExtCtrl = ec;
    cfgForceAddr = fa; cfgForceCtrl = fc; cfgFcsLong = fl;
  endtask

  task automatic modelStep(bit v, logic [7:0] d, bit s, bit e);
    int need;
    bit isBody;
    eHdr = 0; eDv = 0; eLast = 0; eFcsV = 0; eShort = 0;
    if (v && s) begin
      mByp = cfgBypass; mProm = cfgPromisc; mEA = cfgExtAddr; mEC = cfgExtCtrl;
      mFA = cfgForceAddr; mFC = cfgForceCtrl; mFL = cfgFcsLong;
      mInFrame = 1; mq.delete(); mPhase = mByp ? 4 : 0;
    end
    if (v && mInFrame) begin
      need = mFL ? 4 : 2;
      isBody = 0;
      case (mPhase)
        0: begin
          eAddr = {8'h00, d};
          eA2 = mEA && !mProm && (mFA || !d[0]);
          mPhase = eA2 ? 1 : 2;
        end
        1: begin eAddr[15:8] = d; mPhase = 2; end
        2: begin
          eCtrl = {8'h00, d};
          eC2 = mEC && !mProm && (mFC || d[1:0] != 2'b11);
          if (eC2) mPhase = 3;
          else begin mPhase = 4; eHdr = 1; end
        end
        3: begin eCtrl[15:8] = d; mPhase = 4; eHdr = 1; end
        default: isBody = 1;
      endcase
      if (isBody) begin
        if (mq.size() == need) begin
          eData = mq.pop_front(); eDv = 1; eLast = e;
        end
        mq.push_back(d);
      end
      if (e) begin
        if (!isBody || mq.size() < need) eShort = 1;
        else begin
          eFcsV = 1; eFcs = '0;
          for (int i = 0; i < need; i++) eFcs = {eFcs[23:0], mq[i]};
        end
        mInFrame = 0; mq.delete();
      end
    end
  endtask

  task automatic compare();
    bit bad;
    nChecks++;
    bad = (hdrValid !== eHdr) || (addrOut !== eAddr) || (addrTwo !== eA2) ||
          (ctrlOut !== eCtrl) || (ctrlTwo !== eC2) || (dataValid !== eDv) ||
          (eDv && dataOut !== eData) || (dataLast !== eLast) || (fcsValid !== eFcsV) ||
          (eFcsV && fcsOut !== eFcs) || (shortErr !== eShort);
    if (bad) begin
      nErrors++;
      $display("FAIL %s t=%0t actual hdr=%b a=%h/%b c=%h/%b dv=%b d=%h l=%b fv=%b f=%h s=%b expected hdr=%b a=%h/%b c=%h/%b dv=%b d=%h l=%b fv=%b f=%h s=%b",
        curReq, $time, hdrValid, addrOut, addrTwo, ctrlOut, ctrlTwo, dataValid, dataOut,
        dataLast, fcsValid, fcsOut, shortErr, eHdr, eAddr, eA2, eCtrl, eC2, eDv, eData,
        eLast, eFcsV, eFcs, eShort);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, bit s, bit e);
    @(negedge clk);
    inValid = v; inData = d; inSof = s; inEof = e;
    modelStep(v, d, s, e);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  task automatic sendFrm(int gap);
    for (int i = 0; i < frm.size(); i++) begin
      step(1, frm[i], i == 0, i == frm.size() - 1);
      if (gap > 0 && i != frm.size() - 1) idle(gap);
    end
    idle(2);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nErrors++;
    $display("FAIL %s watchdog: actual not finished, expected finish before timeout", curReq);
    finishRun();
  end

  initial begin
    rstN = 0; inValid = 0; inData = 0; inSof = 0; inEof = 0;
    setCfg(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    curReq = "R1";
    compare();
    @(negedge clk);
    rstN = 1;
    idle(2);

    // R2: bypass passes header octets as payload
    curReq = "R2";
    setCfg(1, 0, 0, 0, 0, 0, 0);
    frm = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}; sendFrm(0);
    setCfg(1, 0, 1, 1, 1, 1, 0);
    frm = '{8'h02, 8'h00, 8'hA1, 8'hF0, 8'hF1}; sendFrm(0);

    // R3: address length from bit 0
    curReq = "R3";
    setCfg(0, 0, 1, 0, 0, 0, 0);
    frm = '{8'h02, 8'h35, 8'h13, 8'hD0, 8'hD1, 8'hC0, 8'hC1}; sendFrm(0);
    frm = '{8'h03, 8'h13, 8'hD2, 8'hC2, 8'hC3}; sendFrm(0);
    setCfg(0, 0, 0, 0, 0, 0, 0);
    frm = '{8'h04, 8'h13, 8'hD3, 8'hC4, 8'hC5}; sendFrm(0);

    // R4: address force
    curReq = "R4";
    setCfg(0, 0, 1, 0, 1, 0, 0);
    frm = '{8'h03, 8'h01, 8'h10, 8'hD4, 8'hC6, 8'hC7}; sendFrm(0);
    setCfg(0, 0, 0, 0, 1, 1, 0);
    frm = '{8'h00, 8'h00, 8'hD5, 8'hC8, 8'hC9}; sendFrm(0);

    // R5: control length from low bits
    curReq = "R5";
    setCfg(0, 0, 0, 1, 0, 0, 0);
    frm = '{8'h41, 8'h03, 8'hD6, 8'hCA, 8'hCB}; sendFrm(0);
    frm = '{8'h41, 8'h00, 8'h5A, 8'hD7, 8'hCC, 8'hCD}; sendFrm(0);
    frm = '{8'h41, 8'h01, 8'h5B, 8'hD8, 8'hCE, 8'hCF}; sendFrm(0);

    // R6: control force
    curReq = "R6";
    setCfg(0, 0, 0, 1, 0, 1, 0);
    frm = '{8'h41, 8'h03, 8'h77, 8'hD9, 8'hE0, 8'hE1}; sendFrm(0);

    // R7: promiscuous overrides everything
    curReq = "R7";
    setCfg(0, 1, 1, 1, 1, 1, 0);
    frm = '{8'h02, 8'h00, 8'hDA, 8'hE2, 8'hE3}; sendFrm(0);

    // R8: FCS stripping, both lengths, with gaps
    curReq = "R8";
    setCfg(0, 0, 0, 0, 0, 0, 1);
    frm = '{8'h01, 8'h03, 8'h90, 8'h91, 8'h92, 8'hA0, 8'hA1, 8'hA2, 8'hA3}; sendFrm(0);
    setCfg(1, 0, 0, 0, 0, 0, 1);
    frm = '{8'h93, 8'h94, 8'hA4, 8'hA5, 8'hA6, 8'hA7}; sendFrm(2);
    setCfg(0, 0, 1, 1, 0, 0, 0);
    frm = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h95, 8'h96, 8'hA8, 8'hA9}; sendFrm(1);

    // R9: single payload octet, last with fcs in the same cycle
    curReq = "R9";
    setCfg(0, 0, 0, 0, 0, 0, 0);
    frm = '{8'h21, 8'h13, 8'h97, 8'hAA, 8'hAB}; sendFrm(0);
    frm = '{8'h21, 8'h13, 8'hAC, 8'hAD}; sendFrm(0);

    // R10: short frames at each boundary
    curReq = "R10";
    frm = '{8'h21}; sendFrm(0);
    frm = '{8'h21, 8'h13}; sendFrm(0);
    frm = '{8'h21, 8'h13, 8'hAE}; sendFrm(0);
    setCfg(0, 0, 0, 0, 0, 0, 1);
    frm = '{8'h21, 8'h13, 8'hB0, 8'hB1, 8'hB2}; sendFrm(0);
    setCfg(1, 0, 0, 0, 0, 0, 1);
    frm = '{8'hB3, 8'hB4, 8'hB5}; sendFrm(0);

    // R11: restart in the middle of a frame
    curReq = "R11";
    setCfg(0, 0, 0, 0, 0, 0, 0);
    step(1, 8'h21, 1, 0); step(1, 8'h13, 0, 0); step(1, 8'h98, 0, 0); step(1, 8'h99, 0, 0);
    step(1, 8'h9A, 0, 0);
    frm = '{8'h02, 8'h03, 8'h9B, 8'hB6, 8'hB7}; sendFrm(0);

    // R12: configuration change after the start octet
    curReq = "R12";
    setCfg(0, 0, 1, 1, 0, 0, 0);
    step(1, 8'h02, 1, 0);
    setCfg(1, 1, 0, 0, 1, 1, 1);
    step(1, 8'h55, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h66, 0, 0);
    step(1, 8'h9C, 0, 0);
    step(1, 8'hB8, 0, 0);
    step(1, 8'hB9, 0, 1);
    idle(2);

    // R13: octets outside a frame
    curReq = "R13";
    setCfg(1, 0, 0, 0, 0, 0, 0);
    step(1, 8'hC0, 0, 0); step(1, 8'hC1, 0, 0); step(1, 8'hC2, 0, 1); step(1, 8'hC3, 0, 0);
    idle(3);

    finishRun();
  end

endmodule